// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a clocked static memory whose read and write commands may follow one another in any order with no idle cycle between them. A command is taken on each rising edge at which the active-low clock enable is low. Read data passes through without an output register, so it appears in the clock period right after the edge that took the read address. Write data follows its address by one clock. Because of that delay, a read placed directly after a write sees the bus free in the same cycle that the write data uses.

A load/advance input picks between two cases on each edge. It can load a new address, which gives a new read, a new write, or a deselect decided by three chip selects. It can instead step a two-bit burst counter and repeat the operation of the previous cycle. The counter follows linear or interleaved order, chosen by a static input, and it wraps after four beats. The word is built from 9-bit byte lanes, each with its own active-low write enable. The address width sets the depth. A data-valid/drive flag stands in for a three-state bus, and an asynchronous output enable gates it.

Top module: `zbt_sram`

## Requirements
- R1: After reset the block is deselected and `rdata_drive` is 0.
- R2: On an edge where `clk_en_n` is 1, no state changes. The burst address, the current operation and any write still waiting for its data all stay as they were, and the outputs keep their values. A waiting write takes the data present at the next edge where `clk_en_n` is 0.
- R3: The chip counts as enabled only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If `adv`=0 and the chip is not enabled, the edge starts a deselect, and `rdata_drive` is 0 in the cycle that follows.
- R4: If `adv`=0, the chip is enabled and `wr_n`=1, the edge loads `addr` as a new read. In the cycle right after that edge, `rdata` holds the stored word and `rdata_drive` is 1, provided `oe_n`=0.
- R5: If `adv`=0, the chip is enabled and `wr_n`=0, the edge loads `addr` as a new write. The word is written from `wdata` as sampled at the next enabled edge. Lane i, which is bits [9i+8:9i], is written only when `byte_wr_n[i]`=0. No data is driven in the write cycle.
- R6: If `adv`=1, the edge repeats the previous operation (read, write or deselect) at the next burst address. `addr`, `wr_n` and the chip selects have no effect, but `byte_wr_n` is still used.
- R7: When `order_il`=0 the burst order is linear: the two low address bits step +1 modulo 4 (10,11,00,01). The upper bits stay fixed.
- R8: When `order_il`=1 the burst order is interleaved: the low bits equal the start value XOR the beat number (01,00,11,10).
- R9: A write or burst write with all of `byte_wr_n` high leaves memory unchanged, but it still loads or advances the address.
- R10: `oe_n` acts asynchronously. `rdata_drive` is 0 whenever `oe_n`=1 and in every write, deselect or held-deselect cycle.
- R11: Reads and writes alternate with no gap. A read of an address, placed right after the write to that address, returns the newly written data.
- R12: A burst step taken while deselected stays deselected. It drives nothing and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high holds every state |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Active-low write command |
| byte_wr_n | input | LANES | Active-low per-lane write enables |
| adv | input | 1 | 0 = load address and decode, 1 = burst step |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| wdata | input | LANES*9 | Write data, one clock after its address |
| rdata | output | LANES*9 | Read data, zero when not driven |
| rdata_drive | output | 1 | High when `rdata` would be driven onto the bus |

## Verification
The bench goes after the edge cases of the one-cycle write-data offset. These are a read placed right after a write to the same word, where a design that commits late returns stale data, and a hold placed between a write address and its data, where a design that ignores the hold commits the wrong word. Both burst orders are run through a full wrap. A counter that fails to wrap, or that mixes up the two orders, returns data from the wrong word. Burst steps are issued with garbage address, write strobe and select inputs, which catches a design that re-decodes them. A burst step after a deselect is checked as well, since a careless design would start driving or writing there. An all-disabled byte mask followed by a burst write catches a design that skips the address step when no lane is enabled.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
   localparam int LANE_W = 9;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } zbt_op_e;

   // low two address bits for a given beat of a four-beat burst
   function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       il);
      return il ? (start ^ beat) : (start + beat);
   endfunction
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
   import zbt_pkg::*;
(
   input  logic    adv,
   input  logic    sel_a_n,
   input  logic    sel_b,
   input  logic    sel_c_n,
   input  logic    wr_n,
   input  zbt_op_e op_q,
   output zbt_op_e op_d,
   output logic    load,
   output logic    step
);
   logic chip_on;

   always_comb begin
      chip_on = !sel_a_n && sel_b && !sel_c_n;
      load    = 1'b0;
      step    = 1'b0;
      op_d    = op_q;
      if (adv) begin
         // continue whatever ran last; only an active burst steps
         step = (op_q != OP_IDLE);
      end else if (!chip_on) begin
         op_d = OP_IDLE;
      end else begin
         load = 1'b1;
         op_d = wr_n ? OP_RD : OP_WR;
      end
   end
endmodule

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr
   import zbt_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic          step,
   input  logic          order_il,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] cur_addr
);
   localparam int HI_W = AW - 2;

   logic [HI_W-1:0] hi_q;
   logic [1:0]      start_q;
   logic [1:0]      beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q    <= '0;
         start_q <= 2'd0;
         beat_q  <= 2'd0;
      end else if (tick) begin
         if (load) begin
            hi_q    <= addr_in[AW-1:2];
            start_q <= addr_in[1:0];
            beat_q  <= 2'd0;
         end else if (step) begin
            beat_q  <= beat_q + 2'd1;
         end
      end
   end

   assign cur_addr = {hi_q, burst_lo(start_q, beat_q, order_il)};
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array
   import zbt_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW    = 6
) (
   input  logic                    clk,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && !lane_we_n[g])
            cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[rd_addr];
   end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int LANES = 4,
   parameter int AW    = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    wr_n,
   input  logic [LANES-1:0]        byte_wr_n,
   input  logic                    adv,
   input  logic                    order_il,
   input  logic [AW-1:0]           addr,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rdata_drive
);
   localparam int DW = LANES * LANE_W;

   if (LANES != 2 && LANES != 4) begin : g_bad_lanes
      $error("zbt_sram: LANES must be 2 or 4");
   end
   if (AW < 3 || AW > 12) begin : g_bad_aw
      $error("zbt_sram: AW must lie in 3..12");
   end

   zbt_op_e          op_q, op_d;
   logic             load, step;
   logic [LANES-1:0] be_q;
   logic [AW-1:0]    cur_addr;
   logic [DW-1:0]    arr_q;
   logic             tick;
   logic             commit;

   assign tick = !clk_en_n;

   zbt_cmd_decode u_dec (
      .adv     (adv),
      .sel_a_n (sel_a_n),
      .sel_b   (sel_b),
      .sel_c_n (sel_c_n),
      .wr_n    (wr_n),
      .op_q    (op_q),
      .op_d    (op_d),
      .load    (load),
      .step    (step)
   );

   zbt_burst_addr #(.AW(AW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .step     (step),
      .order_il (order_il),
      .addr_in  (addr),
      .cur_addr (cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_IDLE;
         be_q <= '1;
      end else if (tick) begin
         op_q <= op_d;
         be_q <= byte_wr_n;
      end
   end

   // the write taken last edge receives its data on this edge
   assign commit = tick && (op_q == OP_WR);

   zbt_lane_array #(.LANES(LANES), .AW(AW)) u_mem (
      .clk       (clk),
      .wr_en     (commit),
      .wr_addr   (cur_addr),
      .lane_we_n (be_q),
      .wdata     (wdata),
      .rd_addr   (cur_addr),
      .rdata     (arr_q)
   );

   assign rdata_drive = (op_q == OP_RD) && !oe_n;
   assign rdata       = rdata_drive ? arr_q : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
   import zbt_pkg::*;
#(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en_n,
   input logic          sel_a_n,
   input logic          sel_b,
   input logic          sel_c_n,
   input logic          wr_n,
   input logic          adv,
   input logic          order_il,
   input logic          oe_n,
   input logic          rdata_drive,
   input zbt_op_e       op_q,
   input logic [AW-1:0] cur_addr
);
   logic en;
   assign en = !sel_a_n && sel_b && !sel_c_n;

   p_hold_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en_n |=> ($stable(op_q) && $stable(cur_addr)));

   p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && !en) |=> !rdata_drive);

   p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && en && wr_n) |=> (oe_n || rdata_drive));

   p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && !adv && en && !wr_n) |=> !rdata_drive);

   p_burst_keeps_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv) |=> (op_q == $past(op_q)));

   p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

   p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv && op_q != OP_IDLE && !order_il)
         |=> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

   p_oe_gates_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_drive |-> !oe_n);

   p_desel_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en_n && adv && op_q == OP_IDLE) |=> !rdata_drive);
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clk_en_n    (clk_en_n),
   .sel_a_n     (sel_a_n),
   .sel_b       (sel_b),
   .sel_c_n     (sel_c_n),
   .wr_n        (wr_n),
   .adv         (adv),
   .order_il    (order_il),
   .oe_n        (oe_n),
   .rdata_drive (rdata_drive),
   .op_q        (op_q),
   .cur_addr    (cur_addr)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
   localparam int LANES = 4;
   localparam int AW    = 6;
   localparam int DW    = LANES * 9;
   localparam logic [LANES-1:0] ALL  = '0;
   localparam logic [LANES-1:0] NONE = '1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             clk_en_n = 1'b0;
   logic             sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
   logic             wr_n = 1'b1;
   logic [LANES-1:0] byte_wr_n = '1;
   logic             adv = 1'b0;
   logic             order_il = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic             oe_n = 1'b0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic             rdata_drive;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   zbt_sram #(.LANES(LANES), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_n(wr_n), .byte_wr_n(byte_wr_n), .adv(adv), .order_il(order_il),
      .addr(addr), .oe_n(oe_n), .wdata(wdata),
      .rdata(rdata), .rdata_drive(rdata_drive)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: drive at current point, then land 1 ns after the next falling edge
   task automatic step(input logic ce_n, input logic sa, input logic sb, input logic sc,
                       input logic w, input logic [LANES-1:0] be, input logic ad,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd);
      clk_en_n = ce_n; sel_a_n = sa; sel_b = sb; sel_c_n = sc;
      wr_n = w; byte_wr_n = be; adv = ad; addr = a; wdata = wd;
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   task automatic cmd_wr(input logic [AW-1:0] a, input logic [LANES-1:0] be, input logic [DW-1:0] wd);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, be, 1'b0, a, wd);
   endtask
   task automatic cmd_rd(input logic [AW-1:0] a, input logic [DW-1:0] wd);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, NONE, 1'b0, a, wd);
   endtask
   // burst steps drive junk on address, strobe and selects on purpose
   task automatic cmd_burst(input logic [LANES-1:0] be, input logic [DW-1:0] wd);
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, be, 1'b1, 6'h2A, wd);
   endtask
   task automatic cmd_hold(input logic [DW-1:0] wd);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, ALL, 1'b0, 6'h15, wd);
   endtask
   task automatic cmd_desel(input logic sa, input logic sb, input logic sc);
      step(1'b0, sa, sb, sc, 1'b1, NONE, 1'b0, 6'h00, '0);
   endtask

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                           input logic [LANES-1:0] be_n);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < LANES; i++)
         if (!be_n[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
      return r;
   endfunction

   localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
   localparam logic [DW-1:0] DA = 36'hA_AAAA_AAAA;
   localparam logic [DW-1:0] DB = 36'h5_5555_5555;
   localparam logic [DW-1:0] DE = 36'hE_0E0E_0E0E;
   localparam logic [DW-1:0] DF = 36'hF_1F1F_1F1F;
   localparam logic [DW-1:0] DG = 36'h0_C0DE_CAFE;
   localparam logic [DW-1:0] JUNK = 36'hD_EADB_EEF0;

   function automatic logic [DW-1:0] vbeat(input int k);
      return 36'h3_0000_0000 + DW'(k * 36'h0_1111_1111);
   endfunction

   task automatic t_reset();
      chk("R1 drive after reset", DW'(rdata_drive), DW'(0));
      chk("R1 data after reset", rdata, '0);
   endtask

   task automatic t_write_read();
      cmd_wr(6'd5, ALL, JUNK);
      chk("R5 no drive in write cycle", DW'(rdata_drive), DW'(0));
      cmd_rd(6'd5, D1);
      chk("R11 read right after write", rdata, D1);
      chk("R4 read drives", DW'(rdata_drive), DW'(1));
      cmd_wr(6'd22, ALL, JUNK);
      cmd_rd(6'd5, DG);
      chk("R11 write-read-write turnaround", rdata, D1);
      cmd_rd(6'd22, JUNK);
      chk("R11 write data landed", rdata, DG);
   endtask

   task automatic t_lanes();
      cmd_wr(6'd6, ALL, JUNK);
      cmd_wr(6'd6, 4'b1010, DA);
      cmd_rd(6'd6, DB);
      chk("R5 lane merge", rdata, merge(DA, DB, 4'b1010));
   endtask

   task automatic t_no_lanes();
      cmd_wr(6'd8, ALL, JUNK);
      cmd_wr(6'd8, NONE, DE);
      cmd_burst(ALL, JUNK);
      cmd_rd(6'd8, DF);
      chk("R9 masked write leaves word", rdata, DE);
      cmd_rd(6'd9, JUNK);
      chk("R9 address still advanced", rdata, DF);
   endtask

   task automatic t_linear();
      cmd_wr(6'd16, ALL, JUNK);
      cmd_burst(ALL, vbeat(0));
      cmd_burst(ALL, vbeat(1));
      cmd_burst(ALL, vbeat(2));
      cmd_rd(6'd18, vbeat(3));
      chk("R7 start at 18", rdata, vbeat(2));
      cmd_burst(NONE, JUNK);
      chk("R7 beat 19", rdata, vbeat(3));
      cmd_burst(NONE, JUNK);
      chk("R7 wrap to 16 (R6 inputs ignored)", rdata, vbeat(0));
      cmd_burst(NONE, JUNK);
      chk("R7 beat 17", rdata, vbeat(1));
      cmd_burst(NONE, JUNK);
      chk("R7 back to 18", rdata, vbeat(2));
      chk("R6 burst read drives", DW'(rdata_drive), DW'(1));
   endtask

   task automatic t_interleave();
      cmd_desel(1'b1, 1'b1, 1'b0);
      order_il = 1'b1;
      cmd_rd(6'd17, JUNK);
      chk("R8 start 17", rdata, vbeat(1));
      cmd_burst(NONE, JUNK);
      chk("R8 beat 16", rdata, vbeat(0));
      cmd_burst(NONE, JUNK);
      chk("R8 beat 19", rdata, vbeat(3));
      cmd_burst(NONE, JUNK);
      chk("R8 beat 18", rdata, vbeat(2));
      cmd_desel(1'b1, 1'b1, 1'b0);
      order_il = 1'b0;
   endtask

   task automatic t_hold();
      cmd_rd(6'd16, JUNK);
      cmd_hold(JUNK);
      chk("R2 data held", rdata, vbeat(0));
      cmd_hold(JUNK);
      cmd_burst(NONE, JUNK);
      chk("R2 counter frozen by hold", rdata, vbeat(1));
      cmd_wr(6'd20, ALL, JUNK);
      cmd_hold(JUNK);
      cmd_rd(6'd20, DG);
      chk("R2 pending write takes later data", rdata, DG);
   endtask

   task automatic t_deselect();
      cmd_desel(1'b1, 1'b1, 1'b0);
      chk("R3 sel_a_n high", DW'(rdata_drive), DW'(0));
      cmd_rd(6'd5, JUNK);
      cmd_desel(1'b0, 1'b0, 1'b0);
      chk("R3 sel_b low", DW'(rdata_drive), DW'(0));
      cmd_desel(1'b0, 1'b1, 1'b1);
      chk("R3 sel_c_n high", DW'(rdata_drive), DW'(0));
      cmd_hold(JUNK);
      chk("R10 hold after deselect quiet", DW'(rdata_drive), DW'(0));
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ALL, 1'b1, 6'd5, JUNK);
      chk("R12 burst after deselect quiet", DW'(rdata_drive), DW'(0));
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ALL, 1'b1, 6'd5, JUNK);
      cmd_rd(6'd5, JUNK);
      chk("R12 no write from deselect burst", rdata, D1);
   endtask

   task automatic t_oe();
      cmd_rd(6'd5, JUNK);
      oe_n = 1'b1;
      #1;
      chk("R10 oe high stops drive", DW'(rdata_drive), DW'(0));
      oe_n = 1'b0;
      #1;
      chk("R10 oe low restores drive", DW'(rdata_drive), DW'(1));
      chk("R10 data back", rdata, D1);
      cmd_wr(6'd21, ALL, JUNK);
      chk("R10 no drive in write", DW'(rdata_drive), DW'(0));
      cmd_desel(1'b1, 1'b1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_write_read();
      t_lanes();
      t_no_lanes();
      t_linear();
      t_interleave();
      t_hold();
      t_deselect();
      t_oe();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule